// File: doc/BRIEF.md
# Dual-Capacity Byte FIFO with Water-Level Alerts

This block is a byte-wide first-in first-out buffer behind a four-address register port. Software chooses between two capacities, 255 or 512 bytes. It sets a water level and watches two alert flags. The high flag warns that little free space is left. The low flag warns that few bytes remain. The host writes bytes into the data address and reads them back from the same address in arrival order. A control register reports the capacity mode, both alerts and the upper fill-count bits. A separate length address returns the low byte of the fill count. Writing the flush bit empties the buffer.

Occupancy is tracked by a three-state machine with the states `S_EMPTY`, `S_PARTIAL` and `S_FULL`. It has these transitions:
- `S_EMPTY` to `S_PARTIAL` on an accepted write.
- `S_PARTIAL` to `S_FULL` when the count reaches the capacity.
- `S_PARTIAL` to `S_EMPTY` when the count returns to zero.
- `S_FULL` to `S_PARTIAL` on an accepted read.
- Any state to `S_EMPTY` on a flush.

A write to a full buffer is dropped and sets a sticky overflow flag. A read from an empty buffer returns zero and sets a sticky underflow flag. Changing the capacity mode always flushes, so stale bytes never cross a mode change.

Address map: 0 = data port, 1 = control, 2 = water level bits 7..0, 3 = fill count bits 7..0. The control register holds:
- bit 7: size select.
- bit 6: high alert, read-only.
- bit 5: low alert, read-only.
- bit 4: flush, write-one, reads 0.
- bit 3: reserved, reads 0.
- bit 2: water-level bit 8.
- bits 1..0: fill-count bits 9..8, read-only.

Top module: `byte_fifo_wm`

## Requirements
- R1: After reset the buffer is empty, 255-byte mode is selected, the water level is 0, both sticky flags are clear, and control (address 1) reads 8'hA0.
- R2: Control bit 7 = 1 selects a capacity of 255 bytes and 0 selects 512 bytes. Data writes (address 0) are accepted until the fill count equals the capacity.
- R3: A data read (address 0) returns the oldest stored byte and removes it from the buffer.
- R4: Writing control with bit 4 set empties the buffer and clears both sticky flags. Control bits 4 and 3 always read 0.
- R5: A control write whose bit 7 differs from the current size select flushes the buffer, as in R4.
- R6: Control bit 6 and output `hi_alert` equal (capacity − fill count) ≤ effective water level.
- R7: Control bit 5 and output `lo_alert` equal fill count ≤ effective water level.
- R8: In 512-byte mode the effective water level is {control bit 2, address 2}, and control bits 1..0 read fill-count bits 9..8. In 255-byte mode the effective water level is address 2 alone, and control bits 2..0 read 0.
- R9: A data write while the buffer is full is dropped, and `overflow` goes to 1 and stays there until a flush.
- R10: A data read while the buffer is empty returns 8'h00, and `underflow` goes to 1 and stays there until a flush.
- R11: A data write and a data read in the same cycle both take effect when the buffer is neither empty nor full, and the fill count is unchanged.
- R12: Address 3 reads fill-count bits 7..0. Address 2 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register address (0 data, 1 control, 2 water level, 3 length) |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_rd | input | 1 | Read strobe; at address 0 it pops a byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register, combinational |
| hi_alert | output | 1 | High water alert |
| lo_alert | output | 1 | Low water alert |
| overflow | output | 1 | Sticky flag for a dropped write |
| underflow | output | 1 | Sticky flag for a read while empty |

## Verification
The hardest states to reach are the top of the 512-byte range, where fill-count bits 9..8 and a 9-bit water level decide the alerts. Full-buffer cycles that carry a simultaneous write and read are equally hard to reach. The stimulus reaches them by filling the buffer byte by byte in 512-byte mode with a water level above 255. It then keeps writing and reading together at the full boundary. Mode switches with data still stored are then followed by a long random phase of mixed accesses. Throughout, a queue-based model is compared against every output on every cycle.

// File: rtl/fifo_wm_pkg.sv
package fifo_wm_pkg;

    typedef enum logic [1:0] {
        S_EMPTY   = 2'd0,
        S_PARTIAL = 2'd1,
        S_FULL    = 2'd2
    } fill_state_e;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_CTRL = 2'd1,
        A_WLVL = 2'd2,
        A_LEN  = 2'd3
    } reg_addr_e;

    localparam int CTL_SIZE  = 7;
    localparam int CTL_HI    = 6;
    localparam int CTL_LO    = 5;
    localparam int CTL_FLUSH = 4;
    localparam int CTL_WLMSB = 2;

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_alerts.sv
module fifo_alerts #(
    parameter int CNT_W = 10,
    parameter int WL_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cap,
    input  logic [WL_W-1:0]  level,
    output logic             hi_alert,
    output logic             lo_alert
);

    logic [CNT_W-1:0] level_ext;
    logic [CNT_W-1:0] room;

    always_comb begin
        level_ext = CNT_W'(level);
        room      = cap - count;
        hi_alert  = (room <= level_ext);
        lo_alert  = (count <= level_ext);
    end

    // R7: an empty buffer is always at or below any water level
    a_r7_low_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> lo_alert);

    // R6: a full buffer has zero room, which is at or below any level
    a_r6_high_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (count == cap) |-> hi_alert);

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
    import fifo_wm_pkg::*;
#(
    parameter int DEPTH_BIG   = 512,
    parameter int DEPTH_SMALL = 255,
    parameter int PTR_W       = $clog2(DEPTH_BIG),
    parameter int CNT_W       = $clog2(DEPTH_BIG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic             small_mode,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap,
    output logic             push_ok,
    output fill_state_e      state,
    output logic             overflow,
    output logic             underflow
);

    fill_state_e      state_nxt;
    logic             pop_ok;
    logic [CNT_W-1:0] count_nxt;
    logic [CNT_W-1:0] last_idx;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] lst);
        return (CNT_W'(p) == lst) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        cap       = small_mode ? CNT_W'(DEPTH_SMALL) : CNT_W'(DEPTH_BIG);
        last_idx  = cap - CNT_W'(1);
        push_ok   = push && (state != S_FULL) && !flush;
        pop_ok    = pop && (state != S_EMPTY) && !flush;
        count_nxt = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_EMPTY: begin
                if (push_ok) state_nxt = S_PARTIAL;
            end
            S_PARTIAL: begin
                if (count_nxt == '0)      state_nxt = S_EMPTY;
                else if (count_nxt == cap) state_nxt = S_FULL;
            end
            S_FULL: begin
                if (pop_ok) state_nxt = S_PARTIAL;
            end
            default: state_nxt = S_EMPTY;
        endcase
        if (flush) state_nxt = S_EMPTY;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= state_nxt;
    end

    // pointers and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= step_ptr(wptr, last_idx);
            if (pop_ok)  rptr <= step_ptr(rptr, last_idx);
            count <= count_nxt;
        end
    end

    // outputs: sticky error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else if (flush) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (push && (state == S_FULL))  overflow  <= 1'b1;
            if (pop && (state == S_EMPTY)) underflow <= 1'b1;
        end
    end

    a_r2_count_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap);

    a_r3_empty_state_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EMPTY) == (count == '0));

    a_r4_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && !overflow && !underflow);

    a_r9_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FULL && push && !pop && !flush) |=> $stable(count) && $stable(wptr) && overflow);

    a_r10_empty_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EMPTY && pop && !flush) |=> underflow && $stable(rptr));

    a_r11_push_pop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count));

endmodule

// File: rtl/byte_fifo_wm.sv
module byte_fifo_wm
    import fifo_wm_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH_BIG   = 512,
    parameter int DEPTH_SMALL = 255
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        hi_alert,
    output logic        lo_alert,
    output logic        overflow,
    output logic        underflow
);

    localparam int PTR_W = $clog2(DEPTH_BIG);
    localparam int CNT_W = $clog2(DEPTH_BIG + 1);
    localparam int WL_W  = PTR_W;

    logic              small_q;
    logic [7:0]        wl_lo_q;
    logic              wl_hi_q;
    logic              ctrl_wr, wl_wr, push, pop, flush;
    logic [PTR_W-1:0]  wptr, rptr;
    logic [CNT_W-1:0]  count, cap;
    logic              push_ok;
    fill_state_e       state;
    logic [DATA_W-1:0] head;
    logic [WL_W-1:0]   wl_eff;

    always_comb begin
        ctrl_wr = reg_wr && (reg_addr == A_CTRL);
        wl_wr   = reg_wr && (reg_addr == A_WLVL);
        push    = reg_wr && (reg_addr == A_DATA);
        pop     = reg_rd && (reg_addr == A_DATA);
        flush   = ctrl_wr && (reg_wdata[CTL_FLUSH] || (reg_wdata[CTL_SIZE] != small_q));
        wl_eff  = WL_W'({(wl_hi_q && !small_q), wl_lo_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            small_q <= 1'b1;
            wl_hi_q <= 1'b0;
            wl_lo_q <= '0;
        end else begin
            if (ctrl_wr) begin
                small_q <= reg_wdata[CTL_SIZE];
                wl_hi_q <= reg_wdata[CTL_WLMSB];
            end
            if (wl_wr) wl_lo_q <= reg_wdata;
        end
    end

    fifo_ctrl #(
        .DEPTH_BIG  (DEPTH_BIG),
        .DEPTH_SMALL(DEPTH_SMALL),
        .PTR_W      (PTR_W),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .flush     (flush),
        .small_mode(small_q),
        .wptr      (wptr),
        .rptr      (rptr),
        .count     (count),
        .cap       (cap),
        .push_ok   (push_ok),
        .state     (state),
        .overflow  (overflow),
        .underflow (underflow)
    );

    fifo_store #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH_BIG),
        .ADDR_W(PTR_W)
    ) u_store (
        .clk  (clk),
        .we   (push_ok),
        .waddr(wptr),
        .wdata(reg_wdata[DATA_W-1:0]),
        .raddr(rptr),
        .rdata(head)
    );

    fifo_alerts #(
        .CNT_W(CNT_W),
        .WL_W (WL_W)
    ) u_alerts (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count),
        .cap     (cap),
        .level   (wl_eff),
        .hi_alert(hi_alert),
        .lo_alert(lo_alert)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_DATA: reg_rdata = (state == S_EMPTY) ? 8'h00 : 8'(head);
            A_CTRL: begin
                reg_rdata[CTL_SIZE]  = small_q;
                reg_rdata[CTL_HI]    = hi_alert;
                reg_rdata[CTL_LO]    = lo_alert;
                reg_rdata[CTL_WLMSB] = small_q ? 1'b0 : wl_hi_q;
                reg_rdata[1:0]       = small_q ? 2'b00 : count[CNT_W-1 -: 2];
            end
            A_WLVL: reg_rdata = wl_lo_q;
            A_LEN:  reg_rdata = count[7:0];
            default: reg_rdata = '0;
        endcase
    end

    // R8: in the small mode the count never needs the upper bits
    a_r8_small_count_fits: assert property (@(posedge clk) disable iff (!rst_n)
        small_q |-> (count <= CNT_W'(DEPTH_SMALL)));

    // R5: a size change leaves the buffer empty on the next cycle
    a_r5_size_change_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && (reg_wdata[CTL_SIZE] != small_q)) |=> (count == '0));

endmodule

// File: tb/test_byte_fifo_wm.sv
module test_byte_fifo_wm;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       hi_alert, lo_alert, overflow, underflow;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    byte unsigned q[$];
    bit       m_small = 1;
    bit [7:0] m_wl_lo = 0;
    bit       m_wl_hi = 0;
    bit       m_ovf = 0;
    bit       m_unf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_fifo_wm i_byte_fifo_wm (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .hi_alert (hi_alert),
        .lo_alert (lo_alert),
        .overflow (overflow),
        .underflow(underflow)
    );

    function automatic int m_cap();
        return m_small ? 255 : 512;
    endfunction

    function automatic int m_level();
        return m_small ? int'(m_wl_lo) : int'({m_wl_hi, m_wl_lo});
    endfunction

    function automatic bit m_hi();
        return (m_cap() - q.size()) <= m_level();
    endfunction

    function automatic bit m_lo();
        return q.size() <= m_level();
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] a);
        int n = q.size();
        case (a)
            2'd0: return (n > 0) ? q[0] : 8'h00;
            2'd1: return {m_small, m_hi(), m_lo(), 2'b00,
                          (m_small ? 1'b0 : m_wl_hi),
                          (m_small ? 2'b00 : 2'(n >> 8))};
            2'd2: return m_wl_lo;
            default: return 8'(n);
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic op(input logic [1:0] a, input bit wr, input bit rd,
                      input logic [7:0] wd, input string req);
        int n;
        @(negedge clk);
        reg_addr = a; reg_wr = wr; reg_rd = rd; reg_wdata = wd;
        #(CLK_PERIOD/4);
        check(req, "rdata", int'(reg_rdata), int'(m_read(a)));
        check("R6", "hi_alert", int'(hi_alert), int'(m_hi()));
        check("R7", "lo_alert", int'(lo_alert), int'(m_lo()));
        check("R9", "overflow", int'(overflow), int'(m_ovf));
        check("R10", "underflow", int'(underflow), int'(m_unf));
        @(posedge clk);
        n = q.size();
        if (wr && a == 2'd1) begin
            if (wd[4] || (wd[7] != m_small)) begin
                q.delete(); m_ovf = 0; m_unf = 0;
            end
            m_small = wd[7];
            m_wl_hi = wd[2];
        end
        if (wr && a == 2'd2) m_wl_lo = wd;
        if (a == 2'd0) begin
            bit pop_ok  = rd && (n > 0);
            bit push_ok = wr && (n < m_cap());
            if (rd && n == 0) m_unf = 1;
            if (wr && n >= m_cap()) m_ovf = 1;
            if (pop_ok) void'(q.pop_front());
            if (push_ok) q.push_back(wd);
        end
    endtask

    task automatic idle_read(input logic [1:0] a, input string req);
        op(a, 1'b0, 1'b0, 8'h00, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values, control reads A0
        #(CLK_PERIOD/4);
        reg_addr = 2'd1;
        #1;
        check("R1", "ctrl after reset", int'(reg_rdata), 8'hA0);
        idle_read(2'd1, "R1");
        idle_read(2'd3, "R1");
        idle_read(2'd2, "R1");

        // R7 R6 R3 R12: small water level, a few bytes in and out
        op(2'd2, 1, 0, 8'd3, "R12");
        idle_read(2'd2, "R12");
        for (int i = 0; i < 5; i++) op(2'd0, 1, 0, 8'(i * 7 + 1), "R3");
        idle_read(2'd3, "R12");
        idle_read(2'd1, "R7");
        for (int i = 0; i < 2; i++) op(2'd0, 0, 1, 8'h00, "R3");
        idle_read(2'd1, "R7");

        // R2 R9: fill the small buffer, then one more
        for (int i = 0; i < 260; i++) op(2'd0, 1, 0, 8'(i ^ 8'h5A), "R2");
        idle_read(2'd3, "R2");
        idle_read(2'd1, "R6");
        op(2'd0, 1, 1, 8'hEE, "R9");
        idle_read(2'd3, "R9");

        // R3 R10: drain and read past empty
        for (int i = 0; i < 258; i++) op(2'd0, 0, 1, 8'h00, "R3");
        idle_read(2'd0, "R10");
        op(2'd0, 1, 1, 8'h42, "R10");
        idle_read(2'd0, "R3");

        // R4: flush keeping size, flags clear
        op(2'd1, 1, 0, 8'h90, "R4");
        idle_read(2'd1, "R4");
        idle_read(2'd3, "R4");

        // R5: size change with data stored
        for (int i = 0; i < 10; i++) op(2'd0, 1, 0, 8'(i + 100), "R5");
        op(2'd1, 1, 0, 8'h00, "R5");
        idle_read(2'd3, "R5");
        idle_read(2'd1, "R5");

        // R8: nine-bit water level 300 in 512 mode
        op(2'd2, 1, 0, 8'd44, "R8");
        op(2'd1, 1, 0, 8'h04, "R8");
        for (int i = 0; i < 515; i++) begin
            op(2'd0, 1, 0, 8'(i * 3), "R2");
            if (i % 37 == 0) idle_read(2'd1, "R8");
        end
        idle_read(2'd1, "R8");
        idle_read(2'd3, "R12");
        // R9 R11: write and read together while full
        op(2'd0, 1, 1, 8'h11, "R9");
        op(2'd0, 1, 1, 8'h22, "R11");
        for (int i = 0; i < 300; i++) begin
            op(2'd0, 0, 1, 8'h00, "R3");
            if (i % 41 == 0) idle_read(2'd1, "R8");
        end
        // R11: simultaneous traffic mid-range
        for (int i = 0; i < 50; i++) op(2'd0, 1, 1, 8'(i + 200), "R11");
        idle_read(2'd3, "R11");

        // R8 R5: back to small mode with the level MSB set
        op(2'd1, 1, 0, 8'h84, "R5");
        idle_read(2'd1, "R8");
        for (int i = 0; i < 60; i++) op(2'd0, 1, 0, 8'(i), "R8");
        idle_read(2'd1, "R8");

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(0, 99));
            logic [1:0] a;
            logic [7:0] d = 8'($urandom);
            a = (r < 80) ? 2'd0 : 2'(r % 4);
            if (a == 2'd1 && $urandom_range(0, 3) != 0) d[7] = m_small;
            if (a == 2'd1) d[4] = ($urandom_range(0, 7) == 0);
            op(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), d, "R3");
        end
        idle_read(2'd1, "R6");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule